// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one page table entry from memory. A requester presents a virtual address with an access kind (read, write or instruction fetch). The block adds the scaled page number to a reloadable table base, reads the entry through a request/response memory port, checks the entry's present and permission flags, and answers with a physical address, a cacheable flag and a fault code.

When a translation succeeds and the entry's accessed flag, or for a write its dirty flag, is not yet set, the block writes the updated entry back to the same location before it answers. A faulting translation never writes memory. Only one translation is in flight at a time. The base register is written by a separate port. This lets a context switch point the walker at another table between requests.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req_valid is 0, and the table base is 0.
- R2: One translation at a time. req_ready falls in the cycle after a request is accepted. It stays 0 through the single-cycle rsp_valid pulse and returns to 1 the cycle after.
- R3: The entry read address is base + vpn*4. Here vpn is vaddr[31:12] and base is the register value at acceptance. A base_wr_en write replaces the base for every later request.
- R4: On success (rsp_fault = 0), rsp_paddr = {entry[31:12], vaddr[11:0]}.
- R5: If entry bit 0 (present) is 0, rsp_fault is 1 and rsp_paddr is 0. rsp_cacheable is 0, and no write is sent to memory.
- R6: req_acc encodes 0 = read, 1 = write, 2 = fetch. These need entry bit 1, bit 2 or bit 3 respectively. Code 3 is never permitted. A present entry that lacks the needed bit gives rsp_fault 2, rsp_paddr 0 and no memory write.
- R7: On success, entry bit 4 (accessed) is set, and bit 5 (dirty) is set only for writes. The entry is written back to its own address, other bits unchanged, only if one of these bits was 0.
- R8: On success, rsp_cacheable is the inverse of entry bit 6 (cache-disable).
- R9: While mem_req_valid is 1 and mem_req_ready is 0, the request and its address, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Load the table base register |
| base_wr_data | input | 32 | New table base (physical byte address) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_req_addr | output | 32 | Entry physical address |
| mem_req_wdata | output | 32 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result, one cycle |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_cacheable | output | 1 | Page may be cached |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The properties assume a well-behaved memory side. mem_rsp_valid is raised once per accepted read and only while that read is outstanding, and a write needs no response. The bench's memory model issues exactly one response per read handshake after a programmable latency. It can also hold mem_req_ready low for a set number of cycles, which exercises the hold rule without breaking that assumption. Requests are only raised while req_ready is 1, and the base is reloaded only between translations.

// File: rtl/pt_walker_pkg.sv
// Package: shared types and entry layout for the page table walker.
// Assumes 32-bit entries with the flag positions below; frame in the top bits.
package pt_walker_pkg;

    localparam int ENT_BITS    = 32;
    localparam int BIT_PRESENT = 0;
    localparam int BIT_RD      = 1;
    localparam int BIT_WR      = 2;
    localparam int BIT_EX      = 3;
    localparam int BIT_ACC     = 4;
    localparam int BIT_DIRTY   = 5;
    localparam int BIT_NOCACHE = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_EVAL,
        ST_WB,
        ST_RESP
    } walk_st_t;

endpackage

// File: rtl/pt_base_reg.sv
// Module: holds the physical base address of the active page table.
// Assumes software reloads it between translations; reset value is zero.
module pt_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q
);

    // Load the base on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data;
        end
    end

endmodule

// File: rtl/pt_entry_check.sv
// Module: combinational evaluation of a fetched entry against an access kind.
// Gives the fault code, the entry with accessed/dirty applied, and whether
// write-back is needed. Assumes the entry is stable while it is evaluated.
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic [ENT_BITS-1:0] entry,
    input  acc_t                acc,
    output fault_t              fault,
    output logic                need_wb,
    output logic [ENT_BITS-1:0] entry_upd
);

    logic perm_ok;

    // Select the permission flag the access kind requires.
    always_comb begin
        unique case (acc)
            ACC_READ:  perm_ok = entry[BIT_RD];
            ACC_WRITE: perm_ok = entry[BIT_WR];
            ACC_FETCH: perm_ok = entry[BIT_EX];
            default:   perm_ok = 1'b0;
        endcase
    end

    // Rank the faults: absence first, then protection.
    always_comb begin
        if (!entry[BIT_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if (!perm_ok) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    // Apply the accessed flag always and the dirty flag on writes.
    always_comb begin
        entry_upd = entry;
        entry_upd[BIT_ACC] = 1'b1;
        if (acc == ACC_WRITE) begin
            entry_upd[BIT_DIRTY] = 1'b1;
        end
        need_wb = (fault == FLT_NONE) && (entry_upd != entry);
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Module: sequencer for one translation: entry read, evaluation,
// optional write-back and the single-cycle response.
// Assumes one memory response per accepted read and no write response.
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_W     = 12,
    parameter int ENT_SZ_LOG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENT_BITS-1:0] base_q,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_acc,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [ENT_BITS-1:0] mem_req_addr,
    output logic [ENT_BITS-1:0] mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [ENT_BITS-1:0] mem_rsp_rdata,
    output logic [ENT_BITS-1:0] entry_q,
    output acc_t                acc_q,
    input  fault_t              fault,
    input  logic                need_wb,
    input  logic [ENT_BITS-1:0] entry_upd,
    output logic                rsp_valid,
    output logic [ENT_BITS-1:0] rsp_paddr,
    output logic                rsp_cacheable,
    output logic [1:0]          rsp_fault
);

    localparam int VPN_W = VA_W - PAGE_W;

    walk_st_t              state;
    logic [VA_W-1:0]       va_q;
    logic [ENT_BITS-1:0]   ent_addr_q;
    logic [ENT_BITS-1:0]   ent_offs;

    // Scale the page number to a byte offset inside the table.
    always_comb begin
        ent_offs = ENT_BITS'(req_vaddr[VA_W-1:PAGE_W]) << ENT_SZ_LOG;
    end

    // Advance the walk and capture request, address and entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            acc_q      <= ACC_READ;
            ent_addr_q <= '0;
            entry_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q       <= req_vaddr;
                        acc_q      <= acc_t'(req_acc);
                        ent_addr_q <= base_q + ent_offs;
                        state      <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready) begin
                        state <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        entry_q <= mem_rsp_rdata;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    state <= need_wb ? ST_WB : ST_RESP;
                end
                ST_WB: begin
                    if (mem_req_ready) begin
                        state <= ST_RESP;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the requester handshake and the memory port from the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB);
        mem_req_write = (state == ST_WB);
        mem_req_addr  = ent_addr_q;
        mem_req_wdata = (state == ST_WB) ? entry_upd : '0;
    end

    // Form the response; address and cacheable are zero on any fault.
    always_comb begin
        rsp_valid     = (state == ST_RESP);
        rsp_fault     = rsp_valid ? fault : FLT_NONE;
        rsp_paddr     = '0;
        rsp_cacheable = 1'b0;
        if (rsp_valid && fault == FLT_NONE) begin
            rsp_paddr     = {entry_q[ENT_BITS-1:PAGE_W], va_q[PAGE_W-1:0]};
            rsp_cacheable = !entry_q[BIT_NOCACHE];
        end
    end

    logic unused_vpn_hi;
    assign unused_vpn_hi = ^va_q[VA_W-1:PAGE_W] ^ (VPN_W > 0);

endmodule

// File: rtl/pt_walker.sv
// Module: top of the single-level page table walker.
// Connects the base register, the walk sequencer and the entry checker.
// Assumes a 32-bit virtual and physical address with 4 KB pages.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_W     = 12,
    parameter int ENT_SZ_LOG = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        base_wr_en,
    input  logic [31:0] base_wr_data,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_acc,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_cacheable,
    output logic [1:0]  rsp_fault
);

    logic [ENT_BITS-1:0] base_q;
    logic [ENT_BITS-1:0] entry_q;
    logic [ENT_BITS-1:0] entry_upd;
    acc_t                acc_q;
    fault_t              fault;
    logic                need_wb;

    pt_base_reg #(.ADDR_W(ENT_BITS)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_q  (base_q)
    );

    pt_walk_ctrl #(
        .VA_W       (VA_W),
        .PAGE_W     (PAGE_W),
        .ENT_SZ_LOG (ENT_SZ_LOG)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_q        (base_q),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .entry_q       (entry_q),
        .acc_q         (acc_q),
        .fault         (fault),
        .need_wb       (need_wb),
        .entry_upd     (entry_upd),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_cacheable (rsp_cacheable),
        .rsp_fault     (rsp_fault)
    );

    pt_entry_check u_check (
        .entry     (entry_q),
        .acc       (acc_q),
        .fault     (fault),
        .need_wb   (need_wb),
        .entry_upd (entry_upd)
    );

endmodule

// File: rtl/pt_walker_chk.sv
// Module: property checker bound to pt_walker; watches its ports only.
// Assumes the memory side answers each read once and only while it is pending.
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        base_wr_en,
    input logic [31:0] base_wr_data,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_acc,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        mem_rsp_valid,
    input logic [31:0] mem_rsp_rdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_cacheable,
    input logic [1:0]  rsp_fault
);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_rsp_not_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    p_absent_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd1) |-> (rsp_paddr == 32'd0 && !rsp_cacheable));

    p_fault_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));

    p_prot_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd2) |-> (rsp_paddr == 32'd0 && !rsp_cacheable));

    p_wb_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[4] && mem_req_wdata[0]));

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    logic unused_in;
    assign unused_in = ^{base_wr_en, base_wr_data, req_vaddr, req_acc,
                         mem_rsp_valid, mem_rsp_rdata};

endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_test.sv
// Bench: directed scenarios for pt_walker, one task each, with a memory model.
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // memory model state
    logic [31:0] mem [logic [31:0]];
    int          mem_lat = 1;
    int          stall_cfg = 0;
    int          stall_cnt = 0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int          wr_count = 0;
    int          rd_count = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic        poke_en = 1'b0;
    logic [31:0] poke_addr = '0;
    logic [31:0] poke_data = '0;
    logic        clr_stats = 1'b0;

    // results of the last translation
    logic [31:0] r_paddr;
    logic        r_cache;
    logic [1:0]  r_fault;

    pt_walker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_wr_en    (base_wr_en),
        .base_wr_data  (base_wr_data),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_cacheable (rsp_cacheable),
        .rsp_fault     (rsp_fault)
    );

    always #5 clk = ~clk;

    assign mem_req_ready = (stall_cnt >= stall_cfg);

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'd0;
    endfunction

    // memory model: accepts requests, returns read data after mem_lat cycles
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (clr_stats) begin
            wr_count <= 0;
            rd_count <= 0;
        end
        if (poke_en) mem[poke_addr] = poke_data;
        if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_rd(pend_addr);
            end
        end
        if (mem_req_valid && !mem_req_ready) stall_cnt <= stall_cnt + 1;
        if (mem_req_valid && mem_req_ready) begin
            stall_cnt <= 0;
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_count     <= wr_count + 1;
                last_wr_addr <= mem_req_addr;
                last_wr_data <= mem_req_wdata;
            end else begin
                rd_count     <= rd_count + 1;
                last_rd_addr <= mem_req_addr;
                if (mem_lat <= 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem_rd(mem_req_addr);
                end else begin
                    pend_cnt  <= mem_lat - 1;
                    pend_addr <= mem_req_addr;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_addr = a;
        poke_data = d;
        poke_en   = 1'b1;
        @(negedge clk);
        poke_en   = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = b;
        @(negedge clk);
        base_wr_en   = 1'b0;
    endtask

    // one translation: request, wait for the pulse, check handshake (R2)
    task automatic translate(input logic [31:0] va, input logic [1:0] acc);
        int waited;
        @(negedge clk);
        clr_stats = 1'b1;
        @(negedge clk);
        clr_stats = 1'b0;
        req_vaddr = va;
        req_acc   = acc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", {31'd0, req_ready}, 32'd0);
        waited = 0;
        while (!rsp_valid && waited < 200) begin
            @(negedge clk);
            waited++;
            if (!rsp_valid) begin
                if (req_ready) begin
                    chk(1'b0, "R2", "ready while busy", 32'd1, 32'd0);
                end
            end
        end
        chk(rsp_valid == 1'b1, "R2", "response arrives", {31'd0, rsp_valid}, 32'd1);
        r_paddr = rsp_paddr;
        r_cache = rsp_cacheable;
        r_fault = rsp_fault;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R2", "pulse then idle",
            {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        // base is 0 after reset: vpn 2 entry is read at 0x8
        poke(32'h0000_0008, 32'h0001_1003);
        translate(32'h0000_2004, 2'd0);
        chk(last_rd_addr == 32'h0000_0008, "R1", "reset base", last_rd_addr, 32'h8);
    endtask

    task automatic t_read_first();
        poke(32'h0014_8D14, 32'hABCD_E003);
        translate(32'h1234_5ABC, 2'd0);
        chk(last_rd_addr == 32'h0014_8D14, "R3", "entry address", last_rd_addr, 32'h0014_8D14);
        chk(r_fault == 2'd0, "R4", "fault", {30'd0, r_fault}, 32'd0);
        chk(r_paddr == 32'hABCD_EABC, "R4", "paddr", r_paddr, 32'hABCD_EABC);
        chk(r_cache == 1'b1, "R8", "cacheable", {31'd0, r_cache}, 32'd1);
        chk(wr_count == 1, "R7", "one write-back", wr_count, 32'd1);
        chk(last_wr_addr == 32'h0014_8D14, "R7", "wb address", last_wr_addr, 32'h0014_8D14);
        chk(last_wr_data == 32'hABCD_E013, "R7", "accessed set", last_wr_data, 32'hABCD_E013);
    endtask

    task automatic t_write_dirty();
        poke(32'h0010_000C, 32'h0005_5007);
        translate(32'h0000_3010, 2'd1);
        chk(r_paddr == 32'h0005_5010, "R4", "write paddr", r_paddr, 32'h0005_5010);
        chk(last_wr_data == 32'h0005_5037, "R7", "accessed+dirty", last_wr_data, 32'h0005_5037);
        translate(32'h0000_3020, 2'd1);
        chk(wr_count == 0, "R7", "no wb when flags set", wr_count, 32'd0);
        chk(r_paddr == 32'h0005_5020, "R4", "second paddr", r_paddr, 32'h0005_5020);
        // accessed set but clean: a write must set dirty
        poke(32'h0010_0010, 32'h0006_6017);
        translate(32'h0000_4000, 2'd0);
        chk(wr_count == 0, "R7", "read on accessed page", wr_count, 32'd0);
        translate(32'h0000_4000, 2'd1);
        chk(wr_count == 1 && last_wr_data == 32'h0006_6037, "R7", "dirty only on write",
            last_wr_data, 32'h0006_6037);
    endtask

    task automatic t_absent();
        poke(32'h0010_0014, 32'h0007_7006);
        translate(32'h0000_5000, 2'd0);
        chk(r_fault == 2'd1, "R5", "fault code", {30'd0, r_fault}, 32'd1);
        chk(r_paddr == 32'd0, "R5", "paddr zero", r_paddr, 32'd0);
        chk(r_cache == 1'b0, "R5", "cacheable zero", {31'd0, r_cache}, 32'd0);
        chk(wr_count == 0, "R5", "no write", wr_count, 32'd0);
    endtask

    task automatic t_protect();
        poke(32'h0010_0018, 32'h0008_8003);
        translate(32'h0000_6004, 2'd1);
        chk(r_fault == 2'd2 && r_paddr == 32'd0, "R6", "write to read-only",
            {30'd0, r_fault}, 32'd2);
        chk(wr_count == 0 && mem_rd(32'h0010_0018) == 32'h0008_8003, "R6", "entry untouched",
            mem_rd(32'h0010_0018), 32'h0008_8003);
        translate(32'h0000_6004, 2'd3);
        chk(r_fault == 2'd2, "R6", "reserved kind", {30'd0, r_fault}, 32'd2);
        poke(32'h0010_001C, 32'h0009_9009);
        translate(32'h0000_7FFF, 2'd0);
        chk(r_fault == 2'd2 && wr_count == 0, "R6", "read on exec-only", {30'd0, r_fault}, 32'd2);
        translate(32'h0000_7FFF, 2'd2);
        chk(r_fault == 2'd0 && r_paddr == 32'h0009_9FFF, "R6", "fetch permitted", r_paddr,
            32'h0009_9FFF);
        chk(last_wr_data == 32'h0009_9019, "R7", "fetch sets accessed only", last_wr_data,
            32'h0009_9019);
    endtask

    task automatic t_nocache();
        mem_lat   = 4;
        stall_cfg = 3;
        poke(32'h0010_0020, 32'h000A_A043);
        translate(32'h0000_8123, 2'd0);
        chk(r_cache == 1'b0, "R8", "cache-disable page", {31'd0, r_cache}, 32'd0);
        chk(r_paddr == 32'h000A_A123, "R9", "paddr under stalls", r_paddr, 32'h000A_A123);
        chk(last_wr_data == 32'h000A_A053, "R9", "wb under stalls", last_wr_data, 32'h000A_A053);
        mem_lat   = 1;
        stall_cfg = 0;
    endtask

    task automatic t_reload();
        set_base(32'h0020_0000);
        poke(32'h0020_000C, 32'h000C_C003);
        translate(32'h0000_3010, 2'd0);
        chk(last_rd_addr == 32'h0020_000C, "R3", "reloaded base", last_rd_addr, 32'h0020_000C);
        chk(r_paddr == 32'h000C_C010, "R3", "new table frame", r_paddr, 32'h000C_C010);
        poke(32'h005F_FFFC, 32'hFEDC_B003);
        translate(32'hFFFF_FFFF, 2'd0);
        chk(last_rd_addr == 32'h005F_FFFC, "R3", "top page entry", last_rd_addr, 32'h005F_FFFC);
        chk(r_paddr == 32'hFEDC_BFFF, "R4", "top page paddr", r_paddr, 32'hFEDC_BFFF);
    endtask

    // watchdog: an expired run counts as a failure and still reports
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        set_base(32'h0010_0000);
        t_read_first();
        t_write_dirty();
        t_absent();
        t_protect();
        t_nocache();
        t_reload();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule